// File: doc/BRIEF.md
# SPI Chip-Select Timing Sequencer

This block drives the chip-select lines of an SPI master around the frames that a separate shifter transmits. Before each frame it asserts one line, chosen by an index, and waits a programmable number of serial-clock periods. It then hands the frame to the shifter with a one-cycle start pulse and waits for the shifter's done pulse. Once the frame ends, the sequencer decides whether to keep the line asserted or release it. When it releases the line, it times a tail delay, a minimum inactive time and, when the line is held, a gap between back-to-back frames. All delays are counted in ticks of the same divisor strobe that paces the shifter.

A per-line idle-level mask gives the level that each line rests at. An asserted line is driven to the inverse of its mask bit. Only the implemented lines of the mask are writable, and the other bits read back as zero. Software can therefore write all ones and read back the result to find out how many lines exist. Three chip-select modes are supported:
- Per-frame: assert for each frame and release after it.
- Held: stay asserted between frames.
- Quiet: never assert any line, while frames still run.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset every line rests at level 1, `frame_start` is 0, and `idle_rdata` reads the low NCS bits as ones and all higher bits as zero.
- R2: A cycle with `idle_wr` high stores `idle_wdata[NCS-1:0]` as the idle mask. Bits NCS and above are discarded and read back as zero on `idle_rdata`.
- R3: While a line is asserted, `cs_out` equals the idle mask with bit `cs_sel` inverted. Every other line stays at its mask level. An index of NCS or more asserts no line.
- R4: From the first cycle a line is asserted, `frame_start` rises after exactly `dly_edge[7:0]` sck_tick strobes, or in the next cycle when that field is 0.
- R5: In per-frame mode (`cs_mode` 0, and code 1 behaves the same), after `frame_done` the line stays asserted for exactly `dly_edge[23:16]` further strobes and is then released.
- R6: After a release the lines stay at their mask level for `dly_gap[7:0]` strobes before any reassertion. The lines remain released while `tx_avail` is low.
- R7: In held mode (`cs_mode` 2) the line stays asserted after `frame_done`. When `tx_avail` is high, the next `frame_start` follows after `dly_gap[23:16]` strobes.
- R8: While held and idle, changing `cs_sel` or leaving held mode releases the line after `dly_edge[23:16]` strobes. The inactive time of R6 then applies.
- R9: In quiet mode (`cs_mode` 3), `tx_avail` starts frames directly and `cs_out` never leaves the mask level.
- R10: `frame_start` is a single-cycle pulse. It does not pulse again until the shifter has returned `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_tick | input | 1 | One strobe per serial-clock period, shared with the shifter |
| cs_sel | input | 5 | Index of the line to assert |
| cs_mode | input | 2 | 0/1 per-frame, 2 held, 3 quiet |
| dly_edge | input | 32 | [7:0] lead delay before the first clock, [23:16] tail delay after the last clock |
| dly_gap | input | 32 | [7:0] minimum inactive time, [23:16] gap between held frames |
| idle_wr | input | 1 | Write strobe for the idle mask |
| idle_wdata | input | 32 | Idle mask write data |
| idle_rdata | output | 32 | Idle mask readback, with unimplemented bits at zero |
| tx_avail | input | 1 | Transmit data is waiting |
| frame_done | input | 1 | Shifter finished the frame (single-cycle pulse) |
| frame_start | output | 1 | Start one frame (single-cycle pulse) |
| cs_out | output | NCS | Chip-select lines |

## Verification
The embedded properties assume the following about the inputs:
- The shifter answers each `frame_start` with exactly one single-cycle `frame_done`, and never sends `frame_done` at any other time.
- `cs_sel` and `cs_mode` change only while no line is asserted, or while the line is held with no frame outstanding.

The bench's shifter model returns done once, after a random latency, for each start it sees. Configuration is rewritten only while the sequencer is idle, except for the deliberate index and mode changes in the held state. The tick strobe is random throughout, so every delay measurement counts strobes rather than cycles.

// File: rtl/spi_cssq_pkg.sv
package spi_cssq_pkg;
   typedef enum logic [2:0] {
      CQ_IDLE,   // lines released, waiting for data
      CQ_LEAD,   // line asserted, timing lead delay
      CQ_FRAME,  // shifter busy
      CQ_GAP,    // held line, timing inter-frame gap
      CQ_HELD,   // held line, no frame pending
      CQ_TAIL,   // line asserted, timing tail delay
      CQ_REST    // line released, timing inactive time
   } cq_state_t;

   localparam logic [1:0] MODE_HOLD  = 2'd2;
   localparam logic [1:0] MODE_QUIET = 2'd3;

   localparam int FLD_W   = 8;
   localparam int FLD_LO  = 0;
   localparam int FLD_HI  = 16;
   localparam int IDX_W   = 5;
   localparam int MAX_CS  = 32;
endpackage

// File: rtl/cssq_delay_timer.sv
module cssq_delay_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expire
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= val;
      else if (tick && cnt != 0)  cnt <= cnt - 1'b1;
   end

   // last strobe of the window ends it in the same cycle
   assign expire = (cnt == '0) || (cnt == W'(1) && tick);

   // R4 R5 R6 R7: the count only moves on a strobe or a reload
   assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/cssq_line_drive.sv
module cssq_line_drive
   import spi_cssq_pkg::*;
#(
   parameter int NCS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [31:0]      wdata,
   input  logic             on,
   input  logic [IDX_W-1:0] idx,
   output logic [31:0]      rdata,
   output logic [NCS-1:0]   lines
);
   logic [NCS-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask_q <= '1;
      else if (wr)  mask_q <= wdata[NCS-1:0];
   end

   for (genvar i = 0; i < NCS; i++) begin : g_line
      assign lines[i] = mask_q[i] ^ (on && idx == IDX_W'(i));
   end

   if (NCS < 32) begin : g_pad
      assign rdata = {{(32-NCS){1'b0}}, mask_q};
   end else begin : g_full
      assign rdata = mask_q;
   end

   // R3: at most one line ever departs from its idle level
   assert_one_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lines ^ mask_q));
   // R2: a write lands in the mask one cycle later
   assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (rdata[NCS-1:0] == $past(wdata[NCS-1:0])));
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
   import spi_cssq_pkg::*;
#(
   parameter int NCS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sck_tick,
   input  logic [4:0]       cs_sel,
   input  logic [1:0]       cs_mode,
   input  logic [31:0]      dly_edge,
   input  logic [31:0]      dly_gap,
   input  logic             idle_wr,
   input  logic [31:0]      idle_wdata,
   output logic [31:0]      idle_rdata,
   input  logic             tx_avail,
   input  logic             frame_done,
   output logic             frame_start,
   output logic [NCS-1:0]   cs_out
);
   if (NCS < 1 || NCS > MAX_CS) begin : g_bad_ncs
      $error("NCS must lie in 1..32");
   end

   cq_state_t        state, state_n;
   logic [IDX_W-1:0] act_idx;
   logic             quiet_run;
   logic             start_q;
   logic             cs_on;
   logic             tmr_load, tmr_exp;
   logic [FLD_W-1:0] tmr_val;

   wire [FLD_W-1:0] d_lead = dly_edge[FLD_LO +: FLD_W];
   wire [FLD_W-1:0] d_tail = dly_edge[FLD_HI +: FLD_W];
   wire [FLD_W-1:0] d_rest = dly_gap[FLD_LO +: FLD_W];
   wire [FLD_W-1:0] d_gap  = dly_gap[FLD_HI +: FLD_W];

   always_comb begin
      state_n = state;
      unique case (state)
         CQ_IDLE:  if (tx_avail) state_n = (cs_mode == MODE_QUIET) ? CQ_FRAME : CQ_LEAD;
         CQ_LEAD:  if (tmr_exp) state_n = CQ_FRAME;
         CQ_FRAME: if (frame_done) begin
            if (quiet_run)                 state_n = CQ_IDLE;
            else if (cs_mode == MODE_HOLD) state_n = tx_avail ? CQ_GAP : CQ_HELD;
            else                           state_n = CQ_TAIL;
         end
         CQ_GAP:   if (tmr_exp) state_n = CQ_FRAME;
         CQ_HELD:  if (cs_mode != MODE_HOLD || cs_sel != act_idx) state_n = CQ_TAIL;
                   else if (tx_avail) state_n = CQ_GAP;
         CQ_TAIL:  if (tmr_exp) state_n = CQ_REST;
         CQ_REST:  if (tmr_exp) state_n = (tx_avail && cs_mode != MODE_QUIET) ? CQ_LEAD : CQ_IDLE;
         default:  state_n = CQ_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_n)
         CQ_LEAD: tmr_val = d_lead;
         CQ_GAP:  tmr_val = d_gap;
         CQ_TAIL: tmr_val = d_tail;
         CQ_REST: tmr_val = d_rest;
         default: tmr_val = '0;
      endcase
   end
   assign tmr_load = (state_n != state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= CQ_IDLE;
         act_idx   <= '0;
         quiet_run <= 1'b0;
         start_q   <= 1'b0;
      end else begin
         state   <= state_n;
         start_q <= (state_n == CQ_FRAME) && (state != CQ_FRAME);
         if (state_n == CQ_LEAD && state != CQ_LEAD) act_idx <= cs_sel;
         if (state_n == CQ_FRAME && state != CQ_FRAME) quiet_run <= (state == CQ_IDLE);
      end
   end

   assign cs_on = (state inside {CQ_LEAD, CQ_GAP, CQ_HELD, CQ_TAIL}) ||
                  (state == CQ_FRAME && !quiet_run);
   assign frame_start = start_q;

   cssq_delay_timer #(.W(FLD_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(sck_tick),
      .load(tmr_load), .val(tmr_val), .expire(tmr_exp));

   cssq_line_drive #(.NCS(NCS)) u_lines (
      .clk(clk), .rst_n(rst_n), .wr(idle_wr), .wdata(idle_wdata),
      .on(cs_on), .idx(act_idx), .rdata(idle_rdata), .lines(cs_out));

   // R10: start is one cycle wide and is followed by a busy frame
   assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);
   assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !frame_done) |=> (state == CQ_FRAME));
   // R5 R6: every release opens an inactive window
   assert_release_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_on) |-> (state == CQ_REST));
   // R8: an index swap while held starts the tail
   assert_hold_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CQ_HELD && cs_mode == MODE_HOLD && cs_sel != act_idx) |=> (state == CQ_TAIL));
   // R9: quiet launch leaves every line at its idle level
   assert_quiet_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CQ_IDLE && tx_avail && cs_mode == MODE_QUIET && !idle_wr)
      |=> (frame_start && cs_out == idle_rdata[NCS-1:0]));
endmodule

// File: tb/spi_cs_sequencer_bench.sv
module spi_cs_sequencer_bench;
   localparam int NCS = 4;

   logic clk = 1'b0, rst_n = 1'b0, sck_tick = 1'b0;
   logic [4:0] cs_sel = '0;
   logic [1:0] cs_mode = '0;
   logic [31:0] dly_edge = '0, dly_gap = '0, idle_wdata = '0, idle_rdata;
   logic idle_wr = 1'b0, tx_avail = 1'b0, frame_done = 1'b0, frame_start;
   logic [NCS-1:0] cs_out;

   int n_chk = 0, n_bad = 0;
   logic [NCS-1:0] mask_exp = '1;

   always #2 clk = ~clk;

   spi_cs_sequencer #(.NCS(NCS)) u_spi_cs_sequencer (
      .clk(clk), .rst_n(rst_n), .sck_tick(sck_tick), .cs_sel(cs_sel), .cs_mode(cs_mode),
      .dly_edge(dly_edge), .dly_gap(dly_gap), .idle_wr(idle_wr), .idle_wdata(idle_wdata),
      .idle_rdata(idle_rdata), .tx_avail(tx_avail), .frame_done(frame_done),
      .frame_start(frame_start), .cs_out(cs_out));

   always @(negedge clk) sck_tick <= ($urandom % 3) == 0;

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NCS-1:0] exp_cs(input logic [NCS-1:0] m, input int idx);
      return (idx < NCS) ? (m ^ NCS'(1 << idx)) : m;
   endfunction

   // cond 0: until start, 1: until released, 2: until asserted
   task automatic span(input int cond, output int len, output int tk, output bit last);
      len = 0; tk = 0; last = 0;
      for (int g = 0; g < 3000; g++) begin
         if ((cond == 0 && frame_start) || (cond == 1 && cs_out == mask_exp) ||
             (cond == 2 && cs_out != mask_exp)) return;
         len++; if (sck_tick) tk++; last = sck_tick;
         step();
      end
      chk(0, "span timeout", cond, 0);
   endtask

   task automatic chk_delay(input string req, input int n);
      int len, tk; bit last;
      span((req == "R4" || req == "R7") ? 0 : (req == "R6") ? 2 : 1, len, tk, last);
      if (n == 0) chk(len == 1, req, len, 1);
      else        chk(tk == n && last, req, tk, n);
   endtask

   // shifter model: one done per start after random latency
   task automatic frame(input bit keep_tx);
      int lat = 1 + int'($urandom % 4);
      step();
      for (int k = 0; k < lat; k++) begin
         chk(!frame_start, "R10", frame_start, 0);
         step();
      end
      tx_avail = keep_tx;
      frame_done = 1'b1; step(); frame_done = 1'b0;
   endtask

   task automatic set_mask(input logic [31:0] m);
      idle_wdata = m; idle_wr = 1'b1; step(); idle_wr = 1'b0;
      mask_exp = m[NCS-1:0];
   endtask

   task automatic run_auto(input int idx, input logic [31:0] m, input int dl, input int dt, input int dr);
      int len, tk; bit last;
      set_mask(m);
      dly_edge = {8'h0, 8'(dt), 8'h0, 8'(dl)};
      dly_gap  = {16'h0, 8'h0, 8'(dr)};
      cs_mode = 2'd0; cs_sel = 5'(idx); tx_avail = 1'b1; step();
      span(2, len, tk, last);
      chk(cs_out == exp_cs(mask_exp, idx), "R3", cs_out, exp_cs(mask_exp, idx));
      chk_delay("R4", dl);
      chk(cs_out == exp_cs(mask_exp, idx), "R3", cs_out, exp_cs(mask_exp, idx));
      frame(1'b1);
      chk_delay("R5", dt);
      chk_delay("R6", dr);
      span(0, len, tk, last);
      frame(1'b0);
      chk_delay("R5", dt);
      for (int k = 0; k < 8 + 3 * dr; k++) step();
      chk(cs_out == mask_exp && !frame_start, "R6", cs_out, mask_exp);
   endtask

   initial begin
      int len, tk; bit last;
      void'($urandom(32'd20250607));
      repeat (3) step();
      rst_n = 1'b1; step();
      chk(cs_out == '1 && !frame_start, "R1", cs_out, 4'hF);
      chk(idle_rdata == 32'h0000_000F, "R1", idle_rdata, 32'hF);

      set_mask(32'hFFFF_FFFF);
      chk(idle_rdata == 32'h0000_000F, "R2", idle_rdata, 32'hF);
      set_mask(32'h5A5A_5AA5);
      chk(idle_rdata == 32'h0000_0005, "R2", idle_rdata, 32'h5);

      // directed corners: zero delays, then random configurations
      run_auto(0, 32'hF, 0, 0, 0);
      run_auto(3, 32'h0, 1, 1, 1);
      for (int it = 0; it < 8; it++)
         run_auto(int'($urandom % NCS), $urandom, int'($urandom % 5),
                  int'($urandom % 5), int'($urandom % 5));

      // R3: out-of-range index asserts nothing
      set_mask(32'h6); cs_mode = 2'd0; cs_sel = 5'd6;
      dly_edge = 32'h0002_0002; dly_gap = 32'h0000_0001; tx_avail = 1'b1; step();
      span(0, len, tk, last);
      chk(cs_out == mask_exp, "R3", cs_out, mask_exp);
      frame(1'b0);
      for (int k = 0; k < 30; k++) step();
      chk(cs_out == mask_exp, "R3", cs_out, mask_exp);

      // R7/R8: held mode with gap, index swap releases
      set_mask(32'hF); cs_mode = 2'd2; cs_sel = 5'd1;
      dly_edge = 32'h0003_0002; dly_gap = 32'h0003_0002; tx_avail = 1'b1; step();
      span(2, len, tk, last);
      chk_delay("R4", 2);
      frame(1'b1);
      chk(cs_out == exp_cs(mask_exp, 1), "R7", cs_out, exp_cs(mask_exp, 1));
      chk_delay("R7", 3);
      frame(1'b0);
      for (int k = 0; k < 12; k++) step();
      chk(cs_out == exp_cs(mask_exp, 1) && !frame_start, "R7", cs_out, exp_cs(mask_exp, 1));
      cs_sel = 5'd2; step();
      chk_delay("R8", 3);
      for (int k = 0; k < 20; k++) step();
      chk(cs_out == mask_exp, "R8", cs_out, mask_exp);

      // R8: leaving held mode releases
      cs_sel = 5'd0; dly_edge = 32'h0001_0000; tx_avail = 1'b1; step();
      span(2, len, tk, last);
      span(0, len, tk, last);
      frame(1'b0);
      for (int k = 0; k < 6; k++) step();
      chk(cs_out == exp_cs(mask_exp, 0), "R7", cs_out, exp_cs(mask_exp, 0));
      cs_mode = 2'd0; step();
      chk_delay("R8", 1);

      // R9: quiet mode runs frames with no line asserted
      for (int k = 0; k < 20; k++) step();
      set_mask(32'h9); cs_mode = 2'd3; cs_sel = 5'd1; tx_avail = 1'b1; step();
      for (int f = 0; f < 3; f++) begin
         span(0, len, tk, last);
         chk(frame_start && cs_out == mask_exp, "R9", cs_out, mask_exp);
         frame(f != 2);
         chk(cs_out == mask_exp, "R9", cs_out, mask_exp);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule